// File: doc/BRIEF.md
# Dual-Converter Scan Sequencer

This block runs a programmed scan of up to eight conversions over eight analog inputs, using two converter front ends. Each scan entry names an input channel and whether that conversion is single-ended or differential. The block pulses a start command with the channel and mode to a converter, waits for the converter's done strobe, and then presents the returned sample together with the index of the result slot it belongs in.

There are two modes. In sequential mode only converter A is used, one conversion at a time, and results go to slots 0, 1, 2 and onward. In simultaneous mode both converters start in the same cycle. Pair k takes entry k on converter A and entry k+4 on converter B. Its two results are issued to slot k first and then to slot k+4. A pair whose two entries name the same channel is not converted and raises a sticky error flag.

The whole configuration is captured when the scan starts. A scan runs from a start pulse to a one-cycle end-of-scan pulse, and `busy_o` is high for the whole of that time.

Top module: `scan_seq_top`

## Requirements
- R1: A `start_i` pulse while idle raises `busy_o` on the next cycle. `busy_o` then stays high until the end-of-scan pulse. A `start_i` pulse while `busy_o` is high has no effect.
- R2: In sequential mode only converter A is started, with one conversion outstanding at a time. Step k uses channel `chan_cfg_i[3k+2:3k]` and mode `diff_cfg_i[k]` (1 = differential), and its result is issued with slot k.
- R3: In sequential mode a scan performs exactly `len_i`+1 conversions, taken in step order from 0.
- R4: In simultaneous mode pair k starts both converters in the same cycle: A with entry k and B with entry k+4. The pair's result from A is issued with slot k, and its result from B with slot k+4 on the following cycle. The next pair is issued only after both done strobes for the current pair have arrived.
- R5: In simultaneous mode a `len_i` value above 3 is treated as 3, so a scan holds at most four pairs.
- R6: A simultaneous pair whose two entries name the same channel starts no converter and issues no result, and `err_o` is set. `err_o` holds until the next accepted start, which clears it.
- R7: `eos_o` is high for exactly one cycle, in the cycle after the last result (or after the last skipped pair), and `busy_o` is low in the following cycle.
- R8: Mode, length, channels and modes are sampled at the accepted start. Changing any of them during a scan does not affect that scan.
- R9: After reset `busy_o`, `eos_o`, `err_o`, `res_valid_o` and both converter start outputs are low.
- R10: `res_data_o` carries the data word that the converter returned for the conversion belonging to the reported slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Scan start pulse |
| simul_i | input | 1 | 1 = simultaneous mode, 0 = sequential mode |
| len_i | input | 3 | Scan length minus one |
| chan_cfg_i | input | 24 | Channel of entry k, in bits 3k+2..3k |
| diff_cfg_i | input | 8 | Mode of entry k, 1 = differential |
| conv_a_start_o | output | 1 | Start pulse to converter A |
| conv_a_chan_o | output | 3 | Channel for converter A |
| conv_a_diff_o | output | 1 | Mode for converter A |
| conv_a_done_i | input | 1 | Converter A done strobe |
| conv_a_data_i | input | 12 | Converter A sample, valid with its done strobe |
| conv_b_start_o | output | 1 | Start pulse to converter B |
| conv_b_chan_o | output | 3 | Channel for converter B |
| conv_b_diff_o | output | 1 | Mode for converter B |
| conv_b_done_i | input | 1 | Converter B done strobe |
| conv_b_data_i | input | 12 | Converter B sample, valid with its done strobe |
| res_valid_o | output | 1 | Result strobe |
| res_slot_o | output | 3 | Result slot index |
| res_data_o | output | 12 | Result sample |
| busy_o | output | 1 | Scan in progress |
| eos_o | output | 1 | End-of-scan pulse |
| err_o | output | 1 | Same-channel pair was skipped in the current or most recent scan |

## Verification
Two situations are hard to reach. One is a pair skipped on a channel clash, which only shows up in simultaneous mode when entries k and k+4 match. The other is a clash on the final pair, which must still produce the end-of-scan pulse without any result. The bench builds scans with a clash in a middle pair and one where the only pair clashes.

The converter models answer with different latencies, so the done strobes for a pair arrive in different cycles. This exercises the wait for both strobes.

To check that the configuration is captured at start, the bench rewrites every configuration input in the middle of a scan and pulses start again. It then compares the results against the configuration it had before the rewrite.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_EMIT_A,
    ST_EMIT_B,
    ST_DONE
  } scan_state_e;
endpackage

// File: rtl/scan_cfg_snap.sv
module scan_cfg_snap #(
  parameter int NSTEP = 8,
  parameter int CW    = 3,
  localparam int LW    = $clog2(NSTEP),
  localparam int NPAIR = NSTEP / 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic                simul_i,
  input  logic [LW-1:0]       len_i,
  input  logic [NSTEP*CW-1:0] chan_i,
  input  logic [NSTEP-1:0]    diff_i,
  output logic                simul_o,
  output logic [LW-1:0]       last_o,
  output logic [NSTEP*CW-1:0] chan_o,
  output logic [NSTEP-1:0]    diff_o,
  output logic [NPAIR-1:0]    clash_o
);
  localparam logic [LW-1:0] PAIR_MAX = LW'(NPAIR - 1);

  logic [LW-1:0] last_d;

  // simultaneous scans hold at most NPAIR pairs
  always_comb begin
    last_d = len_i;
    if (simul_i && (len_i > PAIR_MAX)) last_d = PAIR_MAX;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      simul_o <= 1'b0;
      last_o  <= '0;
      chan_o  <= '0;
      diff_o  <= '0;
    end else if (load_i) begin
      simul_o <= simul_i;
      last_o  <= last_d;
      chan_o  <= chan_i;
      diff_o  <= diff_i;
    end
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_clash
    assign clash_o[p] = (chan_o[p*CW +: CW] == chan_o[(p+NPAIR)*CW +: CW]);
  end
endmodule

// File: rtl/scan_step_fsm.sv
module scan_step_fsm
  import scan_seq_pkg::*;
#(
  parameter int NSTEP = 8,
  localparam int LW    = $clog2(NSTEP),
  localparam int NPAIR = NSTEP / 2,
  localparam int PW    = $clog2(NPAIR)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             simul_i,
  input  logic [LW-1:0]    last_i,
  input  logic [NPAIR-1:0] clash_i,
  input  logic             got_a_i,
  input  logic             got_b_i,
  output logic             load_o,
  output logic [LW-1:0]    idx_o,
  output logic             start_a_o,
  output logic             start_b_o,
  output logic             emit_a_o,
  output logic             emit_b_o,
  output logic             busy_o,
  output logic             eos_o,
  output logic             err_o
);
  scan_state_e   state_q;
  logic [LW-1:0] idx_q;
  logic          err_q;
  logic [PW-1:0] pidx;
  logic          skip;
  logic          at_last;
  logic          both_in;

  assign pidx    = idx_q[PW-1:0];
  assign skip    = simul_i && clash_i[pidx];
  assign at_last = (idx_q == last_i);
  assign both_in = got_a_i && (got_b_i || !simul_i);

  assign load_o    = (state_q == ST_IDLE) && start_i;
  assign start_a_o = (state_q == ST_ISSUE) && !skip;
  assign start_b_o = (state_q == ST_ISSUE) && !skip && simul_i;
  assign emit_a_o  = (state_q == ST_EMIT_A);
  assign emit_b_o  = (state_q == ST_EMIT_B);
  assign busy_o    = (state_q != ST_IDLE);
  assign eos_o     = (state_q == ST_DONE);
  assign err_o     = err_q;
  assign idx_o     = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_ISSUE;
          idx_q   <= '0;
          err_q   <= 1'b0;
        end
        ST_ISSUE: if (skip) begin
          err_q <= 1'b1;
          if (at_last) state_q <= ST_DONE;
          else idx_q <= idx_q + 1'b1;
        end else begin
          state_q <= ST_WAIT;
        end
        ST_WAIT: if (both_in) state_q <= ST_EMIT_A;
        ST_EMIT_A, ST_EMIT_B: begin
          if (state_q == ST_EMIT_A && simul_i) begin
            state_q <= ST_EMIT_B;
          end else if (at_last) begin
            state_q <= ST_DONE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_ISSUE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_start_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && !eos_o));
  assert_busy_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !eos_o) |=> busy_o);
  assert_eos_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eos_o |=> (!busy_o && !eos_o));
  assert_pair_clamp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && simul_i) |-> (idx_q < LW'(NPAIR)));
endmodule

// File: rtl/scan_result_path.sv
module scan_result_path #(
  parameter int NSTEP = 8,
  parameter int DW    = 12,
  localparam int LW    = $clog2(NSTEP),
  localparam int NPAIR = NSTEP / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          done_a_i,
  input  logic [DW-1:0] data_a_i,
  input  logic          done_b_i,
  input  logic [DW-1:0] data_b_i,
  input  logic          emit_a_i,
  input  logic          emit_b_i,
  input  logic [LW-1:0] idx_i,
  output logic          got_a_o,
  output logic          got_b_o,
  output logic          res_valid_o,
  output logic [LW-1:0] res_slot_o,
  output logic [DW-1:0] res_data_o
);
  logic [DW-1:0] data_a_q, data_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      got_a_o  <= 1'b0;
      got_b_o  <= 1'b0;
      data_a_q <= '0;
      data_b_q <= '0;
    end else begin
      if (arm_i) got_a_o <= 1'b0;
      else if (done_a_i) begin
        got_a_o  <= 1'b1;
        data_a_q <= data_a_i;
      end
      if (arm_i) got_b_o <= 1'b0;
      else if (done_b_i) begin
        got_b_o  <= 1'b1;
        data_b_q <= data_b_i;
      end
    end
  end

  assign res_valid_o = emit_a_i || emit_b_i;
  assign res_slot_o  = emit_b_i ? (idx_i + LW'(NPAIR)) : idx_i;
  assign res_data_o  = emit_b_i ? data_b_q : data_a_q;

  assert_emit_after_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit_a_i |-> got_a_o);
  assert_emit_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(emit_a_i && emit_b_i));
endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top #(
  parameter int NSTEP = 8,
  parameter int CW    = 3,
  parameter int DW    = 12,
  localparam int LW    = $clog2(NSTEP),
  localparam int NPAIR = NSTEP / 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                simul_i,
  input  logic [LW-1:0]       len_i,
  input  logic [NSTEP*CW-1:0] chan_cfg_i,
  input  logic [NSTEP-1:0]    diff_cfg_i,
  output logic                conv_a_start_o,
  output logic [CW-1:0]       conv_a_chan_o,
  output logic                conv_a_diff_o,
  input  logic                conv_a_done_i,
  input  logic [DW-1:0]       conv_a_data_i,
  output logic                conv_b_start_o,
  output logic [CW-1:0]       conv_b_chan_o,
  output logic                conv_b_diff_o,
  input  logic                conv_b_done_i,
  input  logic [DW-1:0]       conv_b_data_i,
  output logic                res_valid_o,
  output logic [LW-1:0]       res_slot_o,
  output logic [DW-1:0]       res_data_o,
  output logic                busy_o,
  output logic                eos_o,
  output logic                err_o
);
  logic                simul_s;
  logic [LW-1:0]       last_s;
  logic [NSTEP*CW-1:0] chan_s;
  logic [NSTEP-1:0]    diff_s;
  logic [NPAIR-1:0]    clash_s;
  logic                load;
  logic [LW-1:0]       idx;
  logic [LW-1:0]       idx_b;
  logic                got_a, got_b, emit_a, emit_b;

  scan_cfg_snap #(.NSTEP(NSTEP), .CW(CW)) u_cfg (
    .clk_i, .rst_ni,
    .load_i  (load),
    .simul_i (simul_i),
    .len_i   (len_i),
    .chan_i  (chan_cfg_i),
    .diff_i  (diff_cfg_i),
    .simul_o (simul_s),
    .last_o  (last_s),
    .chan_o  (chan_s),
    .diff_o  (diff_s),
    .clash_o (clash_s)
  );

  scan_step_fsm #(.NSTEP(NSTEP)) u_fsm (
    .clk_i, .rst_ni,
    .start_i   (start_i),
    .simul_i   (simul_s),
    .last_i    (last_s),
    .clash_i   (clash_s),
    .got_a_i   (got_a),
    .got_b_i   (got_b),
    .load_o    (load),
    .idx_o     (idx),
    .start_a_o (conv_a_start_o),
    .start_b_o (conv_b_start_o),
    .emit_a_o  (emit_a),
    .emit_b_o  (emit_b),
    .busy_o    (busy_o),
    .eos_o     (eos_o),
    .err_o     (err_o)
  );

  scan_result_path #(.NSTEP(NSTEP), .DW(DW)) u_res (
    .clk_i, .rst_ni,
    .arm_i       (conv_a_start_o),
    .done_a_i    (conv_a_done_i),
    .data_a_i    (conv_a_data_i),
    .done_b_i    (conv_b_done_i),
    .data_b_i    (conv_b_data_i),
    .emit_a_i    (emit_a),
    .emit_b_i    (emit_b),
    .idx_i       (idx),
    .got_a_o     (got_a),
    .got_b_o     (got_b),
    .res_valid_o (res_valid_o),
    .res_slot_o  (res_slot_o),
    .res_data_o  (res_data_o)
  );

  // B takes the upper half of the entry table
  assign idx_b          = idx + LW'(NPAIR);
  assign conv_a_chan_o  = chan_s[idx*CW +: CW];
  assign conv_a_diff_o  = diff_s[idx];
  assign conv_b_chan_o  = chan_s[idx_b*CW +: CW];
  assign conv_b_diff_o  = diff_s[idx_b];

  assert_seq_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_b_start_o |-> (simul_s && conv_a_start_o));
  assert_pair_distinct_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_a_start_o && conv_b_start_o) |-> (conv_a_chan_o != conv_b_chan_o));
  assert_res_in_scan_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (busy_o && !eos_o));
endmodule

// File: tb/scan_seq_top_bench.sv
module scan_seq_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LAT_A = 3;
  localparam int LAT_B = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, simul = 1'b0;
  logic [2:0] len = '0;
  logic [2:0] ch [8];
  logic       df [8];
  logic [23:0] chan_cfg;
  logic [7:0]  diff_cfg;
  logic a_start, a_diff, a_done, b_start, b_diff, b_done;
  logic [2:0] a_chan, b_chan;
  logic [11:0] a_data, b_data;
  logic res_valid, busy, eos, err;
  logic [2:0] res_slot;
  logic [11:0] res_data;

  int n_cmp = 0, n_bad = 0;
  int n_got, a_starts, b_starts, eos_cnt, eos_at;
  logic [2:0]  got_slot [16];
  logic [11:0] got_data [16];
  int exp_n, exp_a, exp_b;
  bit exp_err;
  logic [2:0]  exp_slot [16];
  logic [11:0] exp_data [16];
  int a_cnt = 0, b_cnt = 0;
  logic [11:0] a_pend, b_pend;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int k = 0; k < 8; k++) begin
      chan_cfg[k*3 +: 3] = ch[k];
      diff_cfg[k]        = df[k];
    end
  end

  scan_seq_top u_scan_seq_top (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .simul_i(simul), .len_i(len),
    .chan_cfg_i(chan_cfg), .diff_cfg_i(diff_cfg),
    .conv_a_start_o(a_start), .conv_a_chan_o(a_chan), .conv_a_diff_o(a_diff),
    .conv_a_done_i(a_done), .conv_a_data_i(a_data),
    .conv_b_start_o(b_start), .conv_b_chan_o(b_chan), .conv_b_diff_o(b_diff),
    .conv_b_done_i(b_done), .conv_b_data_i(b_data),
    .res_valid_o(res_valid), .res_slot_o(res_slot), .res_data_o(res_data),
    .busy_o(busy), .eos_o(eos), .err_o(err)
  );

  function automatic logic [11:0] mk(bit is_b, logic d, logic [2:0] c);
    return {is_b, d, 7'd0, c};
  endfunction

  // converter models: data word encodes converter, mode and channel
  always @(negedge clk) begin
    a_done <= 1'b0;
    b_done <= 1'b0;
    if (a_start) begin
      a_cnt  <= LAT_A;
      a_pend <= mk(1'b0, a_diff, a_chan);
    end else if (a_cnt != 0) begin
      a_cnt <= a_cnt - 1;
      if (a_cnt == 1) begin a_done <= 1'b1; a_data <= a_pend; end
    end
    if (b_start) begin
      b_cnt  <= LAT_B;
      b_pend <= mk(1'b1, b_diff, b_chan);
    end else if (b_cnt != 0) begin
      b_cnt <= b_cnt - 1;
      if (b_cnt == 1) begin b_done <= 1'b1; b_data <= b_pend; end
    end
  end

  always @(negedge clk) begin
    if (res_valid && n_got < 16) begin
      got_slot[n_got] = res_slot;
      got_data[n_got] = res_data;
      n_got++;
    end
    if (a_start) a_starts++;
    if (b_start) b_starts++;
    if (eos) begin eos_cnt++; eos_at = n_got; end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic build_exp(bit sm, logic [2:0] ln);
    int last;
    exp_n = 0; exp_a = 0; exp_b = 0; exp_err = 0;
    if (!sm) begin
      for (int k = 0; k <= int'(ln); k++) begin
        exp_slot[exp_n] = 3'(k); exp_data[exp_n] = mk(1'b0, df[k], ch[k]); exp_n++;
        exp_a++;
      end
    end else begin
      last = (ln > 3) ? 3 : int'(ln);
      for (int p = 0; p <= last; p++) begin
        if (ch[p] == ch[p+4]) exp_err = 1;
        else begin
          exp_slot[exp_n] = 3'(p);   exp_data[exp_n] = mk(1'b0, df[p], ch[p]);     exp_n++;
          exp_slot[exp_n] = 3'(p+4); exp_data[exp_n] = mk(1'b1, df[p+4], ch[p+4]); exp_n++;
          exp_a++; exp_b++;
        end
      end
    end
  endtask

  task automatic launch(bit sm, logic [2:0] ln);
    @(negedge clk);
    n_got = 0; a_starts = 0; b_starts = 0; eos_cnt = 0; eos_at = -1;
    simul = sm; len = ln;
    build_exp(sm, ln);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R1 busy after start", int'(busy), 1);
  endtask

  task automatic finish_and_check(string tag);
    bit seen = 0;
    for (int c = 0; c < 4000 && !seen; c++) begin
      @(negedge clk);
      if (eos) seen = 1;
    end
    check(seen, {tag, " R7 eos timeout"}, int'(seen), 1);
    @(negedge clk);
    check(busy == 1'b0, {tag, " R7 busy low after eos"}, int'(busy), 0);
    check(eos_cnt == 1, {tag, " R7 eos count"}, eos_cnt, 1);
    check(eos_at == exp_n, {tag, " R7 eos after last result"}, eos_at, exp_n);
    check(n_got == exp_n, {tag, " R3 result count"}, n_got, exp_n);
    for (int i = 0; i < exp_n && i < n_got; i++) begin
      check(got_slot[i] == exp_slot[i], {tag, " R2/R4 slot"}, int'(got_slot[i]), int'(exp_slot[i]));
      check(got_data[i] == exp_data[i], {tag, " R10 data"}, int'(got_data[i]), int'(exp_data[i]));
    end
    check(a_starts == exp_a, {tag, " R2 conv A starts"}, a_starts, exp_a);
    check(b_starts == exp_b, {tag, " R2 conv B starts"}, b_starts, exp_b);
    check(err == exp_err, {tag, " R6 err flag"}, int'(err), int'(exp_err));
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(!busy && !eos && !err && !res_valid && !a_start && !b_start,
          "R9 reset outputs", int'({busy, eos, err, res_valid, a_start, b_start}), 0);
  endtask

  task automatic t_seq_full;
    for (int k = 0; k < 8; k++) begin ch[k] = 3'(7 - k); df[k] = k[0]; end
    launch(1'b0, 3'd7);
    finish_and_check("seq_full R2");
  endtask

  task automatic t_seq_short;
    for (int k = 0; k < 8; k++) begin ch[k] = 3'((k * 3) % 8); df[k] = (k == 1); end
    launch(1'b0, 3'd2);
    finish_and_check("seq_short R3");
  endtask

  task automatic t_sim_pairs;
    for (int k = 0; k < 8; k++) begin ch[k] = 3'(k); df[k] = (k >= 2 && k <= 5); end
    launch(1'b1, 3'd3);
    finish_and_check("sim_pairs R4");
  endtask

  task automatic t_sim_clamp;
    for (int k = 0; k < 8; k++) begin ch[k] = 3'((k + 5) % 8); df[k] = ~k[1]; end
    launch(1'b1, 3'd7);
    finish_and_check("sim_clamp R5");
  endtask

  task automatic t_sim_clash;
    for (int k = 0; k < 8; k++) begin ch[k] = 3'(k); df[k] = 1'b0; end
    ch[6] = 3'd2;
    launch(1'b1, 3'd3);
    finish_and_check("sim_clash R6");
  endtask

  task automatic t_err_clear;
    for (int k = 0; k < 8; k++) begin ch[k] = 3'(k); df[k] = 1'b1; end
    launch(1'b1, 3'd1);
    finish_and_check("err_clear R6");
  endtask

  task automatic t_clash_only;
    for (int k = 0; k < 8; k++) begin ch[k] = 3'(k); df[k] = 1'b0; end
    ch[4] = 3'd0;
    launch(1'b1, 3'd0);
    finish_and_check("clash_only R6");
  endtask

  task automatic t_busy_ignore;
    for (int k = 0; k < 8; k++) begin ch[k] = 3'((k + 2) % 8); df[k] = k[0] ^ k[2]; end
    launch(1'b0, 3'd5);
    repeat (10) @(negedge clk);
    // R8: rewrite configuration and retrigger mid-scan
    for (int k = 0; k < 8; k++) begin ch[k] = 3'd1; df[k] = 1'b1; end
    simul = 1'b1; len = 3'd1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    finish_and_check("busy_ignore R1 R8");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) begin ch[k] = '0; df[k] = 1'b0; end
    a_done = 1'b0; b_done = 1'b0; a_data = '0; b_data = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_reset;
    t_seq_full;
    t_seq_short;
    t_sim_pairs;
    t_sim_clamp;
    t_sim_clash;
    t_err_clear;
    t_clash_only;
    t_busy_ignore;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule